// File: doc/BRIEF.md
# SPI Flash Page Program Splitter

This block turns one program request, given as a start offset and a byte count, into a series of page-program transactions for a serial NOR flash. None of these transactions crosses a page boundary. The data bytes arrive on a valid/ready byte stream. The block sends them out through a byte-level SPI master, where each byte is offered with a request and completed by an acknowledge that also returns the byte shifted in.

The request is split into chunks. The first chunk runs from the start offset up to the next page boundary. Middle chunks are whole pages. The last chunk is the short remainder. Each chunk goes through the same sequence:

1. Status reads repeat until the busy bit is clear.
2. A write-enable frame is sent.
3. One program frame is sent, holding the opcode, the address of the chunk and its data.

When the request ends, the block reports how many data bytes it programmed. It also flags a request that runs past the device end, and a status poll that never came back ready.

Top module: `spi_page_prog`

## Requirements
- R1: A request whose offset plus count is greater than DEV_BYTES finishes with `done_range_err` set and `done_count` 0, and produces no chip-select frame. A request that ends exactly at DEV_BYTES is accepted.
- R2: A request with count 0 finishes with `done_count` 0 and no error flag, and produces no chip-select frame.
- R3: Before every program frame the block runs status frames. Each status frame is opcode 0x05 followed by one fill byte, and bit 0 of the returned byte means busy. A status frame is repeated while busy reads 1.
- R4: After a status read shows not busy, the block sends a one-byte write-enable frame (0x06) before the program frame.
- R5: A program frame is opcode 0x02, then the chunk start address as ADDR_BYTES bytes with the most significant byte first, then the data bytes in stream order.
- R6: When the page offset (offset modulo PAGE_BYTES) plus the count is at most PAGE_BYTES, the block sends exactly one program frame carrying every byte.
- R7: Otherwise the first frame carries PAGE_BYTES minus the page offset bytes. Each later frame starts at the next page with up to PAGE_BYTES bytes, so no frame holds more than PAGE_BYTES data bytes.
- R8: `done` is a one-cycle pulse. `done_count` equals the number of data bytes sent; opcode and address bytes are not counted.
- R9: If POLL_LIMIT status reads for one chunk in a row all show busy, the request finishes with `done_timeout` set. `done_count` then holds the bytes already programmed.
- R10: While `wr_valid` is low in the data phase, the block makes no byte request. `wr_ready` is high only in a cycle where a data byte is acknowledged.
- R11: Byte requests occur only while `spi_cs_n` is low. `spi_cs_n` goes high for at least one cycle between frames, and is high in idle and after reset.
- R12: `req_ready` is high only while idle. The result outputs keep their values from one `done` until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_offset | input | 8*ADDR_BYTES | Start byte offset in the device |
| req_count | input | 8*ADDR_BYTES+1 | Number of bytes to program |
| wr_valid | input | 1 | Data byte available |
| wr_ready | output | 1 | Data byte taken this cycle |
| wr_data | input | 8 | Data byte |
| spi_cs_n | output | 1 | Chip select, low inside a frame |
| spi_tx_req | output | 1 | Byte offered to the SPI master |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_tx_ack | input | 1 | SPI master finished the offered byte |
| spi_rx_byte | input | 8 | Byte shifted in, valid with the acknowledge |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | 8*ADDR_BYTES+1 | Data bytes programmed |
| done_range_err | output | 1 | Request exceeded the device size |
| done_timeout | output | 1 | Busy poll limit reached |

## Verification
The splitter is tried with several request shapes, and each one separates a different splitting decision:
- A request that fits inside one page, at an inner offset and at an exact page start.
- A request that starts mid-page and crosses several boundaries.
- A request that ends exactly on a boundary, and one that covers the whole device.
- A one-byte tail crossing into the next page.

The recorded frames are compared byte by byte with chunks computed from the requirements. Other runs vary one thing each:
- The number of busy status answers.
- Gaps in the data stream.
- A device that stays busy from the start, and one that turns busy after the first page.

These show that polls are repeated, that the clock stalls rather than sending stale data, and that the partial count is reported. Requests one byte past the device end, and of zero length, check that no frame appears at all.

// File: rtl/pps_pkg.sv
// Shared types and command codes of the page program splitter.
package pps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_CMD,
        ST_POLL_STAT,
        ST_POLL_GAP,
        ST_WEN_CMD,
        ST_WEN_GAP,
        ST_PROG_CMD,
        ST_PROG_ADDR,
        ST_PROG_DATA,
        ST_PROG_GAP,
        ST_FINISH
    } pps_state_e;

    localparam logic [7:0] CMD_PROGRAM  = 8'h02;
    localparam logic [7:0] CMD_WR_EN    = 8'h06;
    localparam logic [7:0] CMD_RD_STAT  = 8'h05;
    localparam logic [7:0] FILL_BYTE    = 8'h00;
    localparam logic [7:0] BUSY_MASK    = 8'h01;

endpackage

// File: rtl/pps_chunk_calc.sv
// Chunk length for the next program frame: the smaller of the bytes left in
// the request and the room left in the current page.
// Assumes PAGE_BYTES is a power of two and CNT_W exceeds log2(PAGE_BYTES).
module pps_chunk_calc #(
    parameter int PAGE_BYTES = 256,
    parameter int CNT_W      = 25,
    localparam int PG_W      = $clog2(PAGE_BYTES)
) (
    input  logic [PG_W-1:0]  page_off,
    input  logic [CNT_W-1:0] remaining,
    output logic [CNT_W-1:0] chunk_len
);
    logic [CNT_W-1:0] room;

    // room to the page end, then clip by the remaining count
    always_comb begin
        room      = CNT_W'(PAGE_BYTES) - CNT_W'(page_off);
        chunk_len = (remaining < room) ? remaining : room;
    end
endmodule

// File: rtl/pps_poll_guard.sv
// Counts consecutive busy status reads for one chunk and flags the read that
// uses up the last allowed attempt. Assumes POLL_LIMIT >= 1.
module pps_poll_guard #(
    parameter int POLL_LIMIT = 100000,
    localparam int PW        = $clog2(POLL_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last_try
);
    logic [PW-1:0] tries;

    // busy read counter, restarted for each chunk
    always_ff @(posedge clk) begin
        if (!rst_n || clear) tries <= '0;
        else if (step)       tries <= tries + 1'b1;
    end

    // the current busy read is the final one permitted
    always_comb last_try = (tries == PW'(POLL_LIMIT - 1));
endmodule

// File: rtl/pps_tx_select.sv
// Chooses the byte offered to the SPI master from the sequencer state:
// opcodes, the big-endian address bytes or the streamed data byte.
module pps_tx_select
    import pps_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    localparam int OFFS_W    = 8 * ADDR_BYTES,
    localparam int IDX_W     = $clog2(ADDR_BYTES)
) (
    input  pps_state_e        state,
    input  logic [IDX_W-1:0]  addr_idx,
    input  logic [OFFS_W-1:0] cur_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        tx_byte
);
    logic [7:0] addr_byte [ADDR_BYTES];

    // most significant address byte goes out first
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
        assign addr_byte[g] = cur_addr[(ADDR_BYTES-1-g)*8 +: 8];
    end

    // byte mux per state
    always_comb begin
        case (state)
            ST_POLL_CMD:  tx_byte = CMD_RD_STAT;
            ST_POLL_STAT: tx_byte = FILL_BYTE;
            ST_WEN_CMD:   tx_byte = CMD_WR_EN;
            ST_PROG_CMD:  tx_byte = CMD_PROGRAM;
            ST_PROG_ADDR: tx_byte = addr_byte[addr_idx];
            ST_PROG_DATA: tx_byte = wr_data;
            default:      tx_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/spi_page_prog.sv
// Page program splitter. Accepts one request (offset, count), checks it
// against the device size and programs it in chunks that never cross a page.
// Each chunk: poll status until not busy, write-enable, one program frame.
// Assumes the SPI master completes one offered byte per acknowledge and only
// acknowledges while a request is offered; data arrive on valid/ready.
module spi_page_prog
    import pps_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int PAGE_BYTES = 256,
    parameter int DEV_BYTES  = 1 << 20,
    parameter int POLL_LIMIT = 100000,
    localparam int OFFS_W    = 8 * ADDR_BYTES,
    localparam int CNT_W     = OFFS_W + 1,
    localparam int PG_W      = $clog2(PAGE_BYTES),
    localparam int IDX_W     = $clog2(ADDR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OFFS_W-1:0] req_offset,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              spi_cs_n,
    output logic              spi_tx_req,
    output logic [7:0]        spi_tx_byte,
    input  logic              spi_tx_ack,
    input  logic [7:0]        spi_rx_byte,
    output logic              done,
    output logic [CNT_W-1:0]  done_count,
    output logic              done_range_err,
    output logic              done_timeout
);
    localparam logic [OFFS_W+1:0] DEV_LIM = (OFFS_W+2)'(DEV_BYTES);

    pps_state_e        state;
    logic [OFFS_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remaining;
    logic [CNT_W-1:0]  chunk_left;
    logic [CNT_W-1:0]  sent;
    logic [CNT_W-1:0]  chunk_len;
    logic [IDX_W-1:0]  addr_idx;
    logic              busy_q;
    logic              fail_range;
    logic              fail_time;
    logic              in_frame;
    logic              byte_done;
    logic              range_bad;
    logic              poll_last;
    logic              poll_clear;
    logic              poll_step;

    // request end beyond device size
    always_comb range_bad = ({2'b00, req_offset} + {1'b0, req_count}) > DEV_LIM;

    // chip-select frame and byte handshake decode
    always_comb begin
        in_frame = (state == ST_POLL_CMD) || (state == ST_POLL_STAT) ||
                   (state == ST_WEN_CMD)  || (state == ST_PROG_CMD)  ||
                   (state == ST_PROG_ADDR) || (state == ST_PROG_DATA);
        spi_cs_n   = !in_frame;
        spi_tx_req = in_frame && ((state != ST_PROG_DATA) || wr_valid);
        byte_done  = spi_tx_req && spi_tx_ack;
        wr_ready   = (state == ST_PROG_DATA) && spi_tx_ack;
        req_ready  = (state == ST_IDLE);
        poll_clear = (state == ST_IDLE) || (state == ST_PROG_GAP);
        poll_step  = (state == ST_POLL_GAP) && busy_q;
    end

    pps_chunk_calc #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_chunk (
        .page_off  (cur_addr[PG_W-1:0]),
        .remaining (remaining),
        .chunk_len (chunk_len)
    );

    pps_poll_guard #(.POLL_LIMIT(POLL_LIMIT)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (poll_clear),
        .step     (poll_step),
        .last_try (poll_last)
    );

    pps_tx_select #(.ADDR_BYTES(ADDR_BYTES)) u_txsel (
        .state    (state),
        .addr_idx (addr_idx),
        .cur_addr (cur_addr),
        .wr_data  (wr_data),
        .tx_byte  (spi_tx_byte)
    );

    // request sequencer: poll, enable, program, repeat per chunk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            cur_addr       <= '0;
            remaining      <= '0;
            chunk_left     <= '0;
            sent           <= '0;
            addr_idx       <= '0;
            busy_q         <= 1'b0;
            fail_range     <= 1'b0;
            fail_time      <= 1'b0;
            done           <= 1'b0;
            done_count     <= '0;
            done_range_err <= 1'b0;
            done_timeout   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_addr   <= req_offset;
                        remaining  <= req_count;
                        sent       <= '0;
                        fail_range <= range_bad;
                        fail_time  <= 1'b0;
                        if (range_bad || (req_count == '0)) state <= ST_FINISH;
                        else                                 state <= ST_POLL_CMD;
                    end
                end
                ST_POLL_CMD:  if (byte_done) state <= ST_POLL_STAT;
                ST_POLL_STAT: begin
                    if (byte_done) begin
                        busy_q <= (spi_rx_byte & BUSY_MASK) != 8'h00;
                        state  <= ST_POLL_GAP;
                    end
                end
                ST_POLL_GAP: begin
                    if (!busy_q)        state <= ST_WEN_CMD;
                    else if (poll_last) begin
                        fail_time <= 1'b1;
                        state     <= ST_FINISH;
                    end else            state <= ST_POLL_CMD;
                end
                ST_WEN_CMD:   if (byte_done) state <= ST_WEN_GAP;
                ST_WEN_GAP: begin
                    chunk_left <= chunk_len;
                    state      <= ST_PROG_CMD;
                end
                ST_PROG_CMD: begin
                    if (byte_done) begin
                        addr_idx <= '0;
                        state    <= ST_PROG_ADDR;
                    end
                end
                ST_PROG_ADDR: begin
                    if (byte_done) begin
                        addr_idx <= addr_idx + 1'b1;
                        if (addr_idx == IDX_W'(ADDR_BYTES - 1)) state <= ST_PROG_DATA;
                    end
                end
                ST_PROG_DATA: begin
                    if (byte_done) begin
                        cur_addr   <= cur_addr + 1'b1;
                        remaining  <= remaining - 1'b1;
                        sent       <= sent + 1'b1;
                        chunk_left <= chunk_left - 1'b1;
                        if (chunk_left == CNT_W'(1)) state <= ST_PROG_GAP;
                    end
                end
                ST_PROG_GAP: state <= (remaining == '0) ? ST_FINISH : ST_POLL_CMD;
                ST_FINISH: begin
                    done           <= 1'b1;
                    done_count     <= sent;
                    done_range_err <= fail_range;
                    done_timeout   <= fail_time;
                    state          <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_page_prog_chk.sv
// Port-level protocol checker for the page program splitter, bound to it.
module spi_page_prog_chk #(
    parameter int PAGE_BYTES = 256,
    parameter int CNT_W      = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             spi_cs_n,
    input logic             spi_tx_req,
    input logic             spi_tx_ack,
    input logic             done,
    input logic [CNT_W-1:0] done_count,
    input logic             done_range_err,
    input logic             done_timeout
);
    logic [31:0] fill;

    // data bytes taken inside the current chip-select frame
    always_ff @(posedge clk) begin
        if (!rst_n || spi_cs_n)       fill <= '0;
        else if (wr_valid && wr_ready) fill <= fill + 1'b1;
    end

    p_req_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_tx_req |-> !spi_cs_n);

    p_take_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (wr_valid && spi_tx_req && spi_tx_ack));

    p_page_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PAGE_BYTES);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_range_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_range_err) |-> (done_count == '0) && !done_timeout);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && !spi_tx_req));

    p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> ($stable(done_count) && $stable(done_timeout)));
endmodule

bind spi_page_prog spi_page_prog_chk #(
    .PAGE_BYTES (PAGE_BYTES),
    .CNT_W      (8 * ADDR_BYTES + 1)
) u_chk (.*);

// File: tb/spi_page_prog_test.sv
`timescale 1ns/1ps
module spi_page_prog_test;
    localparam int AB   = 3;
    localparam int PG   = 16;
    localparam int DEV  = 1024;
    localparam int PLIM = 8;

    typedef struct packed {
        logic [31:0] off;
        logic [31:0] cnt;
        logic [15:0] busy;
        logic [3:0]  stall;
        logic        mid;
        logic [1:0]  err;
        logic [15:0] bytes;
        logic [15:0] frames;
    } vec_t;

    // off, cnt, busy answers, stall gap, turn busy after page 1, err, bytes, frames
    localparam vec_t VECS [12] = '{
        '{32'h000, 32'd16,   16'd0,    4'd0, 1'b0, 2'd0, 16'd16,   16'd3},
        '{32'h005, 32'd4,    16'd2,    4'd0, 1'b0, 2'd0, 16'd4,    16'd5},
        '{32'h00A, 32'd40,   16'd0,    4'd1, 1'b0, 2'd0, 16'd40,   16'd12},
        '{32'h3F0, 32'd16,   16'd0,    4'd0, 1'b0, 2'd0, 16'd16,   16'd3},
        '{32'h3F1, 32'd16,   16'd0,    4'd0, 1'b0, 2'd1, 16'd0,    16'd0},
        '{32'h000, 32'd0,    16'd0,    4'd0, 1'b0, 2'd0, 16'd0,    16'd0},
        '{32'h10F, 32'd2,    16'd1,    4'd0, 1'b0, 2'd0, 16'd2,    16'd7},
        '{32'h020, 32'd33,   16'd0,    4'd2, 1'b0, 2'd0, 16'd33,   16'd9},
        '{32'h040, 32'd20,   16'd1000, 4'd0, 1'b0, 2'd2, 16'd0,    16'd8},
        '{32'h048, 32'd20,   16'd0,    4'd0, 1'b1, 2'd2, 16'd8,    16'd11},
        '{32'h3FF, 32'd1,    16'd0,    4'd0, 1'b0, 2'd0, 16'd1,    16'd3},
        '{32'h000, 32'd1024, 16'd0,    4'd0, 1'b0, 2'd0, 16'd1024, 16'd192}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_offset = '0;
    logic [24:0] req_count = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        spi_cs_n;
    logic        spi_tx_req;
    logic [7:0]  spi_tx_byte;
    logic        spi_tx_ack = 1'b0;
    logic [7:0]  spi_rx_byte = '0;
    logic        done;
    logic [24:0] done_count;
    logic        done_range_err;
    logic        done_timeout;

    spi_page_prog #(.ADDR_BYTES(AB), .PAGE_BYTES(PG), .DEV_BYTES(DEV), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_count(req_count), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_data(wr_data), .spi_cs_n(spi_cs_n),
        .spi_tx_req(spi_tx_req), .spi_tx_byte(spi_tx_byte), .spi_tx_ack(spi_tx_ack),
        .spi_rx_byte(spi_rx_byte), .done(done), .done_count(done_count),
        .done_range_err(done_range_err), .done_timeout(done_timeout)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // frame log filled by the SPI responder
    logic [7:0] lb [2048];
    int fstart [256];
    int flen   [256];
    int nb = 0, nf = 0;
    int busy_budget = 0, wen_seen = 0, stall_set = 0, stall_cnt = 0;
    int data_idx = 0, data_total = 0, req_bad = 0;
    bit mid_mode = 0, ack_data = 0, prev_cs = 1;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 13) + 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // byte-level SPI master and flash model, plus the data stream source
    initial begin
        forever begin
            @(negedge clk);
            if (!spi_cs_n && prev_cs && nf < 256) begin
                fstart[nf] = nb; flen[nf] = 0; nf++;
            end
            prev_cs = spi_cs_n;
            if (spi_tx_ack) begin
                spi_tx_ack = 1'b0;
                if (ack_data) begin
                    data_idx++;
                    if (data_idx >= data_total) wr_valid = 1'b0;
                    else if (stall_set > 0) begin wr_valid = 1'b0; stall_cnt = stall_set; end
                    else wr_data = pat(data_idx);
                end
            end else begin
                if (stall_cnt > 0) begin
                    stall_cnt--;
                    if (stall_cnt == 0) begin wr_valid = 1'b1; wr_data = pat(data_idx); end
                end
                if (spi_tx_req && (spi_cs_n || nf == 0)) req_bad++;
                else if (spi_tx_req) begin
                    automatic int pos = flen[nf-1];
                    automatic logic [7:0] first = (pos == 0) ? spi_tx_byte : lb[fstart[nf-1]];
                    if (first == 8'h02 && pos >= 1 + AB && !wr_valid) req_bad++;
                    if (pos == 0 && spi_tx_byte == 8'h06) wen_seen++;
                    if (pos == 0 && spi_tx_byte == 8'h05 && mid_mode && wen_seen > 0) busy_budget = 1000;
                    if (pos == 1 && first == 8'h05) begin
                        if (busy_budget > 0) begin spi_rx_byte = 8'h01; busy_budget--; end
                        else spi_rx_byte = 8'hFE;
                    end else spi_rx_byte = 8'h01;
                    ack_data = (first == 8'h02) && (pos >= 1 + AB);
                    if (nb < 2048) begin lb[nb] = spi_tx_byte; nb++; end
                    flen[nf-1]++;
                    spi_tx_ack = 1'b1;
                end
            end
        end
    end

    // walks the log against chunks derived from offset, count and page size
    function automatic bit walk_ok(input int off, input int cnt, input int busy);
        int f = 0;
        int addr = off;
        int rem = cnt;
        int di = 0;
        int polls = 0;
        int pages = 0;
        int chunk;
        int s;
        bit ok = 1;
        while (rem > 0 && ok) begin
            while (f < nf && flen[f] == 2 && lb[fstart[f]] == 8'h05) begin polls++; f++; end
            if (f >= nf || flen[f] != 1 || lb[fstart[f]] != 8'h06) ok = 0;
            else f++;
            chunk = PG - (addr % PG);
            if (rem < chunk) chunk = rem;
            if (ok) begin
                if (f >= nf || flen[f] != 4 + chunk) ok = 0;
                else begin
                    s = fstart[f];
                    if (lb[s] != 8'h02 || lb[s+1] != 8'(addr >> 16) ||
                        lb[s+2] != 8'(addr >> 8) || lb[s+3] != 8'(addr)) ok = 0;
                    for (int k = 0; k < chunk; k++)
                        if (lb[s+4+k] != pat(di + k)) ok = 0;
                end
                f++;
            end
            addr += chunk; rem -= chunk; di += chunk; pages++;
        end
        if (f != nf) ok = 0;
        if (polls != busy + pages) ok = 0;
        return ok;
    endfunction

    task automatic run_vec(input vec_t v);
        int code;
        nb = 0; nf = 0; req_bad = 0; wen_seen = 0; stall_cnt = 0;
        busy_budget = int'(v.busy); mid_mode = v.mid; stall_set = int'(v.stall);
        data_idx = 0; data_total = int'(v.cnt);
        wr_data = pat(0); wr_valid = (v.cnt != 0);
        @(negedge clk);
        req_valid = 1'b1; req_offset = v.off[23:0]; req_count = v.cnt[24:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R12 ready while running", int'(req_ready), 0);
        while (!done) @(negedge clk);
        code = done_timeout ? 2 : (done_range_err ? 1 : 0);
        chk(code == int'(v.err), "R1/R9 result flags", code, int'(v.err));
        chk(int'(done_count) == int'(v.bytes), "R8 byte count", int'(done_count), int'(v.bytes));
        chk(nf == int'(v.frames), "R2/R3/R4 frame count", nf, int'(v.frames));
        if (v.err == 2'd0 && v.cnt != 0)
            chk(walk_ok(int'(v.off), int'(v.cnt), int'(v.busy)), "R5/R6/R7 frame content", 0, 1);
        chk(req_bad == 0, "R10/R11 request discipline", req_bad, 0);
        wr_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11 R12: quiet outputs in reset and just after
        chk(spi_cs_n && !spi_tx_req && !done && !wr_ready, "R11 reset outputs", int'(spi_cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && spi_cs_n && done_count == 0, "R12 idle after reset", int'(req_ready), 1);
        for (int i = 0; i < 12; i++) run_vec(VECS[i]);
        // R12: result held between requests
        run_vec(VECS[0]);
        repeat (20) @(negedge clk);
        chk(done_count == 25'd16 && !done && !done_timeout, "R12 result held", int'(done_count), 16);
        // R6: page-aligned short write after a timeout run
        run_vec(VECS[8]);
        run_vec('{32'h030, 32'd5, 16'd0, 4'd0, 1'b0, 2'd0, 16'd5, 16'd3});
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule